// File: doc/BRIEF.md
# Single-Bit Alias Access Bridge

This bridge sits between one bus master and a downstream memory or register bus. It gives every bit of a target byte its own 32-bit address in one of two alias windows. A store to an alias word becomes a locked read, modify and write of the target byte, so that exactly one bit is set or cleared and nothing else can reach the target in between. A load from an alias word returns that single bit. Any address outside both alias windows is forwarded unchanged.

There are two windows. The first covers the memory region: alias base 0x22000000, target base 0x20000000. The second covers the peripheral region: alias base 0x42000000, target base 0x40000000. Each window spans 32 MB of alias space and covers the first 1 MB of its target. For an alias address A in a window, the target byte is the target base plus `(A - alias base) >> 5`, and the bit number is `A[4:2]`.

Both sides use a request handshake with valid and ready. Upstream, the master raises `up_valid` and holds all request fields steady until it sees `up_ready`. `up_ready` is a one-cycle completion pulse, and `up_rdata` is valid in that cycle. A master that keeps `up_valid` high in the following cycle starts a new request. Downstream, the bridge holds `dn_valid` and every request field steady until it sees `dn_ready`. A read's `dn_rdata` is taken in the cycle where `dn_valid` and `dn_ready` are both high. Only one transaction is in flight at a time.

Top module: `bitband_bridge`

## Requirements
- R1: An access outside both alias windows (for example 0x21FFFFFC or 0x24000000) makes exactly one downstream transfer. That transfer carries the original address, write flag, write data and byte enables, with lock low. A read returns the downstream word unchanged.
- R2: Alias address A in [0x22000000, 0x23FFFFFF] maps to byte 0x20000000 + ((A-0x22000000)>>5), bit A[4:2]. Alias address A in [0x42000000, 0x43FFFFFF] maps to byte 0x40000000 + ((A-0x42000000)>>5), bit A[4:2]. Downstream target accesses use the word-aligned byte address, with byte enable bit equal to the byte address bits [1:0].
- R3: An alias write sets the target bit when write data bit 0 is 1 and clears it when bit 0 is 0. Write data bits 31:1 have no effect.
- R4: An alias write leaves the other seven bits of the target byte, and the other bytes of its word, unchanged. Its downstream write enables exactly one byte lane.
- R5: An alias read makes a single downstream read and no write. It returns 0x00000000 or 0x00000001, equal to the current target bit.
- R6: An alias write issues a target read and then a target write. `dn_lock` rises together with that read request and stays high until the cycle after the write is accepted. `dn_lock` is low for pass-through accesses and for alias reads.
- R7: `up_ready` stays low until all downstream transfers of the transaction have completed. It is then high for exactly one cycle, and `dn_valid` is low in that cycle. An alias write returns 0x00000000.
- R8: While `dn_valid` is high and `dn_ready` is low, `dn_valid`, `dn_write`, `dn_addr`, `dn_wdata` and `dn_be` hold their values.
- R9: During reset, `up_ready`, `dn_valid` and `dn_lock` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| up_valid | input | 1 | Upstream request present |
| up_ready | output | 1 | Upstream completion pulse |
| up_write | input | 1 | 1 = store, 0 = load |
| up_addr | input | ADDR_W | Request byte address |
| up_wdata | input | DATA_W | Store data |
| up_be | input | DATA_W/8 | Store byte enables |
| up_rdata | output | DATA_W | Load result, valid with up_ready |
| dn_valid | output | 1 | Downstream request present |
| dn_ready | input | 1 | Downstream accepts and completes request |
| dn_write | output | 1 | Downstream store flag |
| dn_addr | output | ADDR_W | Downstream byte address |
| dn_wdata | output | DATA_W | Downstream store data |
| dn_be | output | DATA_W/8 | Downstream byte enables |
| dn_rdata | input | DATA_W | Downstream load data |
| dn_lock | output | 1 | Keeps the downstream arbiter on this master |

## Verification
A wrong address split or a wrong window compare shows up in the next downstream request: it has the wrong byte address or byte lane, so the transfer log shows it before the transaction ends. A wrong merge or a wrong captured set value shows up at once in the target byte of the bench memory, where it is compared with the reference after every alias store. A controller state that leaves out a target write, releases the lock early or pulses ready too soon shows up in the same transaction: the transfer count is wrong, lock is low during the locked pair, or `up_ready` is seen while the transfer log is still incomplete.

// File: rtl/bb_pkg.sv
package bb_pkg;

  localparam int unsigned BYTE_W = 8;
  localparam int unsigned BIT_SEL_W = 3;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_PASS = 3'd1,
    S_TRD  = 3'd2,
    S_MOD  = 3'd3,
    S_TWR  = 3'd4,
    S_RSP  = 3'd5
  } bb_state_e;

endpackage

// File: rtl/bb_alias_decode.sv
module bb_alias_decode #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned WIN_COUNT = 2,
  parameter int unsigned SPAN_LOG2 = 25,
  parameter int unsigned SHIFT = 5,
  parameter logic [WIN_COUNT-1:0][ADDR_W-1:0] ALIAS_BASE = '0,
  parameter logic [WIN_COUNT-1:0][ADDR_W-1:0] TARGET_BASE = '0
) (
  input  logic [ADDR_W-1:0]             addr,
  output logic                          hit,
  output logic [ADDR_W-1:0]             tgt,
  output logic [bb_pkg::BIT_SEL_W-1:0]  bit_idx
);

  localparam int unsigned OFS_W = SPAN_LOG2 - SHIFT;

  logic [WIN_COUNT-1:0] win_hit;
  logic [ADDR_W-1:0]    win_tgt [WIN_COUNT];

  for (genvar w = 0; w < WIN_COUNT; w++) begin : g_win
    assign win_hit[w] = (addr[ADDR_W-1:SPAN_LOG2] == ALIAS_BASE[w][ADDR_W-1:SPAN_LOG2]);
    assign win_tgt[w] = TARGET_BASE[w] + ADDR_W'(addr[SPAN_LOG2-1:SHIFT]);
  end

  always_comb begin
    hit = 1'b0;
    tgt = addr;
    for (int i = 0; i < int'(WIN_COUNT); i++) begin
      if (win_hit[i] && !hit) begin
        hit = 1'b1;
        tgt = win_tgt[i];
      end
    end
  end

  assign bit_idx = addr[SHIFT-1:SHIFT-bb_pkg::BIT_SEL_W];

  logic unused_lsb;
  assign unused_lsb = ^addr[SHIFT-bb_pkg::BIT_SEL_W-1:0] ^ (OFS_W == 0);

endmodule

// File: rtl/bb_bit_merge.sv
module bb_bit_merge #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned LANES = DATA_W / 8,
  parameter int unsigned LANE_W = $clog2(LANES)
) (
  input  logic [DATA_W-1:0]             rd_word,
  input  logic [LANE_W-1:0]             lane,
  input  logic [bb_pkg::BIT_SEL_W-1:0]  bit_idx,
  input  logic                          set_val,
  output logic                          cur_bit,
  output logic [DATA_W-1:0]             wr_word,
  output logic [LANES-1:0]              lane_be
);

  logic [bb_pkg::BYTE_W-1:0] cur_byte;
  logic [bb_pkg::BYTE_W-1:0] new_byte;

  always_comb begin
    cur_byte = rd_word[bb_pkg::BYTE_W*lane +: bb_pkg::BYTE_W];
    cur_bit  = cur_byte[bit_idx];
    new_byte = cur_byte;
    new_byte[bit_idx] = set_val;
  end

  assign wr_word = {LANES{new_byte}};
  assign lane_be = LANES'(1) << lane;

endmodule

// File: rtl/bb_rmw_ctrl.sv
module bb_rmw_ctrl
  import bb_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned LANES = DATA_W / 8,
  parameter int unsigned LANE_W = $clog2(LANES)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   up_valid,
  input  logic                   up_write,
  input  logic [ADDR_W-1:0]      up_addr,
  input  logic [DATA_W-1:0]      up_wdata,
  input  logic [LANES-1:0]       up_be,
  output logic                   up_ready,
  output logic [DATA_W-1:0]      up_rdata,
  input  logic                   dec_hit,
  input  logic [ADDR_W-1:0]      dec_tgt,
  input  logic [BIT_SEL_W-1:0]   dec_bit,
  output logic [DATA_W-1:0]      mrg_word,
  output logic [LANE_W-1:0]      mrg_lane,
  output logic [BIT_SEL_W-1:0]   mrg_bit,
  output logic                   mrg_set,
  input  logic                   mrg_cur_bit,
  input  logic [DATA_W-1:0]      mrg_wr_word,
  input  logic [LANES-1:0]       mrg_be,
  output logic                   dn_valid,
  input  logic                   dn_ready,
  output logic                   dn_write,
  output logic [ADDR_W-1:0]      dn_addr,
  output logic [DATA_W-1:0]      dn_wdata,
  output logic [LANES-1:0]       dn_be,
  input  logic [DATA_W-1:0]      dn_rdata,
  output logic                   dn_lock
);

  bb_state_e            state;
  logic                 r_write;
  logic [ADDR_W-1:0]    r_addr;
  logic [DATA_W-1:0]    r_wdata;
  logic [LANES-1:0]     r_be;
  logic [BIT_SEL_W-1:0] r_bit;
  logic [DATA_W-1:0]    r_rword;
  logic [DATA_W-1:0]    r_wnew;
  logic [DATA_W-1:0]    r_resp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      r_write <= 1'b0;
      r_addr  <= '0;
      r_wdata <= '0;
      r_be    <= '0;
      r_bit   <= '0;
      r_rword <= '0;
      r_wnew  <= '0;
      r_resp  <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          if (up_valid) begin
            r_write <= up_write;
            r_addr  <= dec_hit ? dec_tgt : up_addr;
            r_wdata <= up_wdata;
            r_be    <= up_be;
            r_bit   <= dec_bit;
            state   <= dec_hit ? S_TRD : S_PASS;
          end
        end
        S_PASS: begin
          if (dn_ready) begin
            r_resp <= dn_rdata;
            state  <= S_RSP;
          end
        end
        S_TRD: begin
          if (dn_ready) begin
            r_rword <= dn_rdata;
            state   <= S_MOD;
          end
        end
        S_MOD: begin
          if (r_write) begin
            r_wnew <= mrg_wr_word;
            state  <= S_TWR;
          end else begin
            r_resp <= DATA_W'(mrg_cur_bit);
            state  <= S_RSP;
          end
        end
        S_TWR: begin
          if (dn_ready) begin
            r_resp <= '0;
            state  <= S_RSP;
          end
        end
        S_RSP:   state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  logic in_pass;
  logic in_target;

  assign in_pass   = (state == S_PASS);
  assign in_target = (state == S_TRD) || (state == S_TWR);

  assign dn_valid = in_pass || in_target;
  assign dn_write = in_pass ? r_write : (state == S_TWR);
  assign dn_addr  = in_pass ? r_addr : {r_addr[ADDR_W-1:LANE_W], LANE_W'(0)};
  assign dn_wdata = in_pass ? r_wdata : r_wnew;
  assign dn_be    = in_pass ? r_be : mrg_be;
  assign dn_lock  = r_write && (in_target || (state == S_MOD));

  assign up_ready = (state == S_RSP);
  assign up_rdata = r_resp;

  assign mrg_word = r_rword;
  assign mrg_lane = r_addr[LANE_W-1:0];
  assign mrg_bit  = r_bit;
  assign mrg_set  = r_wdata[0];

endmodule

// File: rtl/bitband_bridge.sv
module bitband_bridge #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned WIN_COUNT = 2,
  parameter int unsigned ALIAS_SPAN_LOG2 = 25,
  parameter logic [WIN_COUNT-1:0][ADDR_W-1:0] ALIAS_BASE  = {32'h4200_0000, 32'h2200_0000},
  parameter logic [WIN_COUNT-1:0][ADDR_W-1:0] TARGET_BASE = {32'h4000_0000, 32'h2000_0000}
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  up_valid,
  output logic                  up_ready,
  input  logic                  up_write,
  input  logic [ADDR_W-1:0]     up_addr,
  input  logic [DATA_W-1:0]     up_wdata,
  input  logic [DATA_W/8-1:0]   up_be,
  output logic [DATA_W-1:0]     up_rdata,
  output logic                  dn_valid,
  input  logic                  dn_ready,
  output logic                  dn_write,
  output logic [ADDR_W-1:0]     dn_addr,
  output logic [DATA_W-1:0]     dn_wdata,
  output logic [DATA_W/8-1:0]   dn_be,
  input  logic [DATA_W-1:0]     dn_rdata,
  output logic                  dn_lock
);

  localparam int unsigned LANES  = DATA_W / 8;
  localparam int unsigned LANE_W = $clog2(LANES);
  localparam int unsigned SHIFT  = LANE_W + bb_pkg::BIT_SEL_W;

  logic                          dec_hit;
  logic [ADDR_W-1:0]             dec_tgt;
  logic [bb_pkg::BIT_SEL_W-1:0]  dec_bit;
  logic [DATA_W-1:0]             mrg_word;
  logic [LANE_W-1:0]             mrg_lane;
  logic [bb_pkg::BIT_SEL_W-1:0]  mrg_bit;
  logic                          mrg_set;
  logic                          mrg_cur_bit;
  logic [DATA_W-1:0]             mrg_wr_word;
  logic [LANES-1:0]              mrg_be;

  bb_alias_decode #(
    .ADDR_W(ADDR_W), .WIN_COUNT(WIN_COUNT), .SPAN_LOG2(ALIAS_SPAN_LOG2),
    .SHIFT(SHIFT), .ALIAS_BASE(ALIAS_BASE), .TARGET_BASE(TARGET_BASE)
  ) u_dec (
    .addr(up_addr), .hit(dec_hit), .tgt(dec_tgt), .bit_idx(dec_bit)
  );

  bb_rmw_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES), .LANE_W(LANE_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .up_valid(up_valid), .up_write(up_write), .up_addr(up_addr),
    .up_wdata(up_wdata), .up_be(up_be), .up_ready(up_ready), .up_rdata(up_rdata),
    .dec_hit(dec_hit), .dec_tgt(dec_tgt), .dec_bit(dec_bit),
    .mrg_word(mrg_word), .mrg_lane(mrg_lane), .mrg_bit(mrg_bit), .mrg_set(mrg_set),
    .mrg_cur_bit(mrg_cur_bit), .mrg_wr_word(mrg_wr_word), .mrg_be(mrg_be),
    .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_write(dn_write),
    .dn_addr(dn_addr), .dn_wdata(dn_wdata), .dn_be(dn_be),
    .dn_rdata(dn_rdata), .dn_lock(dn_lock)
  );

  bb_bit_merge #(
    .DATA_W(DATA_W), .LANES(LANES), .LANE_W(LANE_W)
  ) u_merge (
    .rd_word(mrg_word), .lane(mrg_lane), .bit_idx(mrg_bit), .set_val(mrg_set),
    .cur_bit(mrg_cur_bit), .wr_word(mrg_wr_word), .lane_be(mrg_be)
  );

endmodule

// File: rtl/bb_bridge_checker.sv
module bb_bridge_checker #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned WIN_COUNT = 2,
  parameter int unsigned ALIAS_SPAN_LOG2 = 25,
  parameter logic [WIN_COUNT-1:0][ADDR_W-1:0] ALIAS_BASE = '0
) (
  input logic                clk,
  input logic                rst_n,
  input logic                up_valid,
  input logic                up_ready,
  input logic                up_write,
  input logic [ADDR_W-1:0]   up_addr,
  input logic [DATA_W-1:0]   up_rdata,
  input logic                dn_valid,
  input logic                dn_ready,
  input logic                dn_write,
  input logic [ADDR_W-1:0]   dn_addr,
  input logic [DATA_W-1:0]   dn_wdata,
  input logic [DATA_W/8-1:0] dn_be,
  input logic                dn_lock
);

  logic up_alias;
  always_comb begin
    up_alias = 1'b0;
    for (int i = 0; i < int'(WIN_COUNT); i++)
      if (up_addr[ADDR_W-1:ALIAS_SPAN_LOG2] == ALIAS_BASE[i][ADDR_W-1:ALIAS_SPAN_LOG2])
        up_alias = 1'b1;
  end

  logic unused_low;
  assign unused_low = ^up_addr[ALIAS_SPAN_LOG2-1:0];

  assert_dn_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid && !dn_ready |=> dn_valid && $stable(dn_write) && $stable(dn_addr)
                              && $stable(dn_wdata) && $stable(dn_be));

  assert_lock_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dn_lock) |-> dn_valid && !dn_write);

  assert_lock_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dn_lock) |-> $past(dn_valid && dn_ready && dn_write));

  assert_one_lane_R4: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid && dn_write && dn_lock |-> $countones(dn_be) == 1);

  assert_ready_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    up_ready |=> !up_ready);

  assert_ready_after_dn_R7: assert property (@(posedge clk) disable iff (!rst_n)
    up_ready |-> !dn_valid);

  assert_alias_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    up_ready && up_valid && !up_write && up_alias |-> up_rdata[DATA_W-1:1] == '0);

endmodule

bind bitband_bridge bb_bridge_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WIN_COUNT(WIN_COUNT),
  .ALIAS_SPAN_LOG2(ALIAS_SPAN_LOG2), .ALIAS_BASE(ALIAS_BASE)
) u_chk (.*);

// File: tb/tb_bitband_bridge.sv
module tb_bitband_bridge;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        up_valid = 1'b0;
  logic        up_ready;
  logic        up_write = 1'b0;
  logic [31:0] up_addr = '0;
  logic [31:0] up_wdata = '0;
  logic [3:0]  up_be = '0;
  logic [31:0] up_rdata;
  logic        dn_valid;
  logic        dn_ready = 1'b0;
  logic        dn_write;
  logic [31:0] dn_addr;
  logic [31:0] dn_wdata;
  logic [3:0]  dn_be;
  logic [31:0] dn_rdata = '0;
  logic        dn_lock;

  always #10 clk = ~clk;

  bitband_bridge dut (.*);

  int n_chk = 0;
  int n_fail = 0;
  int cycles = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Downstream memory and reference model
  bit [7:0] mem [bit [31:0]];
  bit [7:0] ref_mem [bit [31:0]];

  function automatic logic [7:0] seed_byte(input logic [31:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h5A;
  endfunction
  function automatic logic [7:0] mem_get(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : seed_byte(a);
  endfunction
  function automatic logic [7:0] ref_get(input logic [31:0] a);
    return ref_mem.exists(a) ? ref_mem[a] : seed_byte(a);
  endfunction
  function automatic logic [31:0] ref_word(input logic [31:0] a);
    logic [31:0] b = {a[31:2], 2'b00};
    return {ref_get(b + 3), ref_get(b + 2), ref_get(b + 1), ref_get(b)};
  endfunction
  function automatic logic [31:0] mem_word(input logic [31:0] a);
    logic [31:0] b = {a[31:2], 2'b00};
    return {mem_get(b + 3), mem_get(b + 2), mem_get(b + 1), mem_get(b)};
  endfunction

  function automatic bit alias_map(input logic [31:0] a, output logic [31:0] tgt,
                                   output logic [2:0] b);
    tgt = a;
    b = a[4:2];
    if (a >= 32'h2200_0000 && a < 32'h2400_0000) begin
      tgt = 32'h2000_0000 + ((a - 32'h2200_0000) >> 5);
      return 1'b1;
    end
    if (a >= 32'h4200_0000 && a < 32'h4400_0000) begin
      tgt = 32'h4000_0000 + ((a - 32'h4200_0000) >> 5);
      return 1'b1;
    end
    return 1'b0;
  endfunction

  // Transfer log per transaction
  int          hs_n = 0;
  logic        hs_write [4];
  logic        hs_lock  [4];
  logic [31:0] hs_addr  [4];
  logic [31:0] hs_wdata [4];
  logic [3:0]  hs_be    [4];

  int          lat = 0;
  bit          pend = 1'b0;
  logic [31:0] p_addr, p_wdata;
  logic [3:0]  p_be;
  logic        p_write;

  always @(negedge clk) begin
    dn_ready = 1'b0;
    if (dn_valid) begin
      if (pend) begin
        check(dn_write == p_write && dn_addr == p_addr && dn_wdata == p_wdata && dn_be == p_be,
              "R8", "request held under back-pressure", dn_addr, p_addr);
      end
      if (lat == 0) begin
        dn_ready = 1'b1;
        pend = 1'b0;
        if (hs_n < 4) begin
          hs_write[hs_n] = dn_write;
          hs_lock[hs_n]  = dn_lock;
          hs_addr[hs_n]  = dn_addr;
          hs_wdata[hs_n] = dn_wdata;
          hs_be[hs_n]    = dn_be;
        end
        hs_n++;
        if (dn_write) begin
          for (int i = 0; i < 4; i++)
            if (dn_be[i]) mem[{dn_addr[31:2], 2'b00} + i] = dn_wdata[8*i +: 8];
        end else begin
          dn_rdata = mem_word(dn_addr);
        end
        lat = $urandom % 3;
      end else begin
        lat--;
        pend = 1'b1;
        p_addr = dn_addr; p_wdata = dn_wdata; p_be = dn_be; p_write = dn_write;
      end
    end
  end

  task automatic access(input logic w, input logic [31:0] a, input logic [31:0] d,
                        input logic [3:0] be, output logic [31:0] rd);
    @(negedge clk);
    hs_n = 0;
    up_valid = 1'b1; up_write = w; up_addr = a; up_wdata = d; up_be = be;
    do begin
      @(negedge clk);
      if (up_ready) check(!dn_valid, "R7", "no downstream request with ready", 32'(dn_valid), 0);
    end while (!up_ready);
    rd = up_rdata;
    @(negedge clk);
    up_valid = 1'b0;
    check(!up_ready, "R7", "ready is a single pulse", 32'(up_ready), 0);
  endtask

  task automatic run_op(input logic w, input logic [31:0] a, input logic [31:0] d,
                        input logic [3:0] be);
    logic [31:0] tgt, rd, exp;
    logic [2:0]  b;
    logic [7:0]  nb;
    bit hit;
    hit = alias_map(a, tgt, b);
    if (!hit) begin
      exp = ref_word(a);
      access(w, a, d, be, rd);
      check(hs_n == 1, "R1", "pass-through transfer count", hs_n, 1);
      check(hs_addr[0] == a && hs_write[0] == w && hs_be[0] == be && hs_wdata[0] == d,
            "R1", "pass-through fields", hs_addr[0], a);
      check(!hs_lock[0], "R6", "no lock on pass-through", 32'(hs_lock[0]), 0);
      if (!w) check(rd == exp, "R1", "pass-through read data", rd, exp);
      else for (int i = 0; i < 4; i++)
        if (be[i]) ref_mem[{a[31:2], 2'b00} + i] = d[8*i +: 8];
    end else if (!w) begin
      exp = {31'b0, ref_get(tgt)[b]};
      access(1'b0, a, d, be, rd);
      check(rd == exp, "R5", "alias read bit", rd, exp);
      check(hs_n == 1 && !hs_write[0], "R5", "single target read", hs_n, 1);
      check(hs_addr[0] == {tgt[31:2], 2'b00} && hs_be[0] == (4'b1 << tgt[1:0]),
            "R2", "target word address", hs_addr[0], {tgt[31:2], 2'b00});
      check(!hs_lock[0], "R6", "no lock on alias read", 32'(hs_lock[0]), 0);
    end else begin
      nb = ref_get(tgt);
      nb[b] = d[0];
      ref_mem[tgt] = nb;
      access(1'b1, a, d, be, rd);
      check(rd == 32'h0, "R7", "alias write response", rd, 0);
      check(hs_n == 2 && !hs_write[0] && hs_write[1], "R6", "read then write", hs_n, 2);
      check(hs_lock[0] && hs_lock[1], "R6", "lock over both transfers",
            {hs_lock[0], hs_lock[1]}, 2'b11);
      check(hs_addr[1] == {tgt[31:2], 2'b00}, "R2", "target write address",
            hs_addr[1], {tgt[31:2], 2'b00});
      check(hs_be[1] == (4'b1 << tgt[1:0]), "R4", "single byte lane", hs_be[1],
            4'b1 << tgt[1:0]);
      check(mem_get(tgt)[b] == d[0], "R3", "target bit value", mem_get(tgt), nb);
      check(mem_word(tgt) == ref_word(tgt), "R4", "neighbour bits intact",
            mem_word(tgt), ref_word(tgt));
    end
  endtask

  initial begin
    logic [31:0] rd;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(!up_ready && !dn_valid && !dn_lock, "R9", "reset outputs",
          {up_ready, dn_valid, dn_lock}, 0);
    rst_n = 1'b1;

    // Window edges and mapping (R2)
    run_op(1'b1, 32'h2200_0000, 32'h0000_0001, 4'hF);
    run_op(1'b0, 32'h2200_0000, 32'h0, 4'hF);
    run_op(1'b1, 32'h23FF_FFFC, 32'hFFFF_FFFE, 4'hF);  // R3 upper data ignored
    run_op(1'b0, 32'h23FF_FFFC, 32'h0, 4'hF);
    run_op(1'b1, 32'h4200_001C, 32'h8000_0001, 4'hF);
    run_op(1'b0, 32'h4200_001C, 32'h0, 4'hF);
    run_op(1'b1, 32'h43FF_FFE0, 32'hFFFF_FFFF, 4'hF);
    // Just outside windows (R1)
    run_op(1'b0, 32'h21FF_FFFC, 32'h0, 4'hF);
    run_op(1'b0, 32'h2400_0000, 32'h0, 4'hF);
    run_op(1'b1, 32'h3000_0003, 32'hA5A5_A5A5, 4'b1000);
    run_op(1'b0, 32'h3000_0000, 32'h0, 4'hF);

    // Read, invert, write back sequence
    for (int k = 0; k < 4; k++) begin
      logic [31:0] t; logic [2:0] bb; bit h;
      h = alias_map(32'h2200_0104, t, bb);
      access(1'b0, 32'h2200_0104, 32'h0, 4'hF, rd);
      check(h && rd == {31'b0, ref_get(t)[bb]}, "R5", "toggle read", rd, {31'b0, ref_get(t)[bb]});
      run_op(1'b1, 32'h2200_0104, {31'b0, ~rd[0]}, 4'hF);
    end

    // Constrained random mix
    for (int n = 0; n < 400; n++) begin
      logic [31:0] tb_base, ab, ofs, d, a;
      logic [2:0]  bit_n;
      logic [3:0]  be;
      int kind;
      tb_base = ($urandom % 2) ? 32'h4000_0000 : 32'h2000_0000;
      ab      = tb_base + 32'h0200_0000;
      ofs     = $urandom % 16;
      bit_n   = 3'($urandom);
      d       = $urandom;
      be      = 4'($urandom);
      kind    = $urandom % 4;
      case (kind)
        0: run_op(1'b0, (tb_base + ofs) & ~32'h3, d, 4'hF);
        1: run_op(1'b1, (tb_base + ofs) & ~32'h3, d, be);
        2: begin a = ab + ofs * 32 + 32'(bit_n) * 4; run_op(1'b0, a, d, 4'hF); end
        default: begin a = ab + ofs * 32 + 32'(bit_n) * 4; run_op(1'b1, a, d, 4'hF); end
      endcase
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

endmodule